// File: doc/BRIEF.md
# Microscaling float widening converter

This block widens one packed low-precision floating-point code into the exactly equal value in a wider IEEE-style format. The source code is 8, 6 or 4 bits wide. A run-time source-format select chooses one of five encodings, and a destination select chooses half, bfloat16, single or double precision. The result sits right-aligned on a 64-bit bus.

Each source format has its own rules for infinity and NaN. One 8-bit format has full IEEE-style special values. The other 8-bit format has a single NaN code and no infinity. The 6-bit and 4-bit formats are finite only. The block splits the code into sign, exponent and mantissa and classifies it. Normal values are rebiased. Subnormal values are normalized with a leading-zero count. The output is then chosen by a fixed priority.

There is one register stage. A request presented with `valid_in` comes out one clock later with `valid_out`. An unsupported source-format value gives a zero result and raises an error flag.

Top module: `mx_widen`

## Requirements
- R1: `src_fmt` selects the source encoding: 0 = E5M2 (bias 15), 1 = E4M3FN (bias 7), 2 = E3M2FN (bias 3), 3 = E2M3FN (bias 1), 4 = E2M1FN (bias 1). The code is right-aligned in `code_in`, laid out from the top as sign, exponent, then mantissa. Bits of `code_in` above the selected width are ignored.
- R2: `dst_fmt` selects the output: 0 = half (5/10 bits, bias 15), 1 = bfloat16 (8/7, bias 127), 2 = single (8/23, bias 127), 3 = double (11/52, bias 1023). The result is laid out sign, exponent, mantissa and is right-aligned in `result`. All bits above the destination width are zero.
- R3: For a normal input, the output exponent is the source exponent field plus (destination bias minus source bias). The source mantissa is shifted left by the difference in mantissa widths. The value is exact.
- R4: For a subnormal input (exponent zero, mantissa nonzero), the leading set mantissa bit becomes the implicit one. The output exponent comes from that bit's position and the remaining fraction is left-aligned. If the value lies below the destination's normal range (E5M2 to half), the output is a destination subnormal with an equal value.
- R5: For E5M2, an all-ones exponent with a zero mantissa gives a signed infinity (exponent all ones, mantissa zero). An all-ones exponent with a nonzero mantissa is a NaN.
- R6: For E4M3FN, only the code whose exponent and mantissa bits are all ones is a NaN. Every other all-ones-exponent code converts as a normal number. No code gives infinity.
- R7: E3M2FN, E2M3FN and E2M1FN have no special values. Every code converts to a finite number.
- R8: Any NaN input gives the canonical quiet NaN: sign 0, exponent all ones, and only the top mantissa bit set. The input sign is dropped.
- R9: A zero input (exponent and mantissa zero) gives a zero of the same sign: only the sign bit is set.
- R10: A `src_fmt` value of 5, 6 or 7 gives an all-zero `result` with `fmt_err` = 1. Supported formats give `fmt_err` = 0.
- R11: `result`, `fmt_err` and `valid_out` change exactly one clock after a cycle with `valid_in` high. After a cycle without `valid_in`, `valid_out` is 0 and `result` holds its last value.
- R12: A synchronous active-low reset clears `valid_out`, `result` and `fmt_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Request strobe |
| src_fmt | input | 3 | Source encoding select |
| dst_fmt | input | 2 | Destination format select |
| code_in | input | 8 | Right-aligned source code |
| valid_out | output | 1 | Result strobe, one clock after `valid_in` |
| result | output | 64 | Right-aligned destination bit pattern |
| fmt_err | output | 1 | Unsupported source format |

## Verification
Every code of each of the five source formats is converted to all four destinations. The expected bits are built from a real-number decode of the code followed by an arithmetic re-encode. This separates the zero, subnormal, normal, infinity and NaN paths of each format, and it shows that the E4M3FN all-ones-exponent codes are still numbers. The E5M2-to-half sweep covers the case where a subnormal must stay subnormal. The 6-bit and 4-bit sweeps set the unused upper input bits to alternating junk to show they are ignored. Unsupported format values, idle cycles and reset are tried separately.

// File: rtl/mx_widen.sv
module mx_widen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_in,
  input  logic [2:0]  src_fmt,
  input  logic [1:0]  dst_fmt,
  input  logic [7:0]  code_in,
  output logic        valid_out,
  output logic [63:0] result,
  output logic        fmt_err
);

  int eb, mb, sb, kind;
  int dw, dm, de, db;
  int ne, se, p;
  logic       ok, sgn;
  logic [7:0] emask, mmask, shd;
  logic [4:0] ef;
  logic [2:0] mf, lz;
  logic       e_ones, is_nan, is_inf, is_zero, is_sub;
  logic [63:0] sign_w, eall, norm_m, sub_m, sub_e, fin, qnan, res;

  always_comb begin
    ok = 1'b1; eb = 5; mb = 2; sb = 15; kind = 0;
    case (src_fmt)
      3'd0: begin eb = 5; mb = 2; sb = 15; kind = 0; end
      3'd1: begin eb = 4; mb = 3; sb = 7;  kind = 1; end
      3'd2: begin eb = 3; mb = 2; sb = 3;  kind = 2; end
      3'd3: begin eb = 2; mb = 3; sb = 1;  kind = 2; end
      3'd4: begin eb = 2; mb = 1; sb = 1;  kind = 2; end
      default: ok = 1'b0;
    endcase
    case (dst_fmt)
      2'd0: begin dw = 16; dm = 10; de = 5;  db = 15;   end
      2'd1: begin dw = 16; dm = 7;  de = 8;  db = 127;  end
      2'd2: begin dw = 32; dm = 23; de = 8;  db = 127;  end
      default: begin dw = 64; dm = 52; de = 11; db = 1023; end
    endcase

    emask = 8'((1 << eb) - 1);
    mmask = 8'((1 << mb) - 1);
    shd   = code_in >> mb;
    ef    = shd[4:0] & emask[4:0];
    mf    = code_in[2:0] & mmask[2:0];
    sgn   = code_in[3'(eb + mb)];

    e_ones  = (ef == emask[4:0]);
    is_zero = (ef == 5'd0) && (mf == 3'd0);
    is_sub  = (ef == 5'd0) && (mf != 3'd0);
    is_inf  = (kind == 0) && e_ones && (mf == 3'd0);
    case (kind)
      0:       is_nan = e_ones && (mf != 3'd0);
      1:       is_nan = e_ones && (mf == mmask[2:0]);
      default: is_nan = 1'b0;
    endcase

    lz = mf[2] ? 3'd0 : (mf[1] ? 3'd1 : 3'd2);
    p  = 2 - int'(lz);

    ne     = int'(ef) + db - sb;
    norm_m = 64'(mf) << (dm - mb);

    se = p + 1 - sb - mb + db;
    if (se > 0) begin
      sub_e = 64'(se);
      sub_m = 64'(mf ^ (3'b001 << p)) << (dm - p);
    end else begin
      sub_e = 64'd0;
      sub_m = 64'(mf) << (dm - mb);
    end

    sign_w = 64'(sgn) << (dw - 1);
    eall   = 64'((1 << de) - 1) << dm;
    qnan   = eall | (64'd1 << (dm - 1));
    fin    = is_sub ? (sign_w | (sub_e << dm) | sub_m)
                    : (sign_w | (64'(ne) << dm) | norm_m);

    if (!ok)          res = 64'd0;
    else if (is_nan)  res = qnan;
    else if (is_inf)  res = sign_w | eall;
    else if (is_zero) res = sign_w;
    else              res = fin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= 64'd0;
      fmt_err   <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result  <= res;
        fmt_err <= !ok;
      end
    end
  end

  // R11
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && $stable(result)));

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && fmt_err) |-> (result == 64'd0));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && dst_fmt != 2'd3) |=> (result[63:32] == 32'd0));

  // R8
  canon_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && src_fmt == 3'd1 && code_in[6:0] == 7'h7f && dst_fmt == 2'd2)
    |=> (result == 64'h7fc0_0000));

  // R7
  finite_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && src_fmt >= 3'd2 && src_fmt <= 3'd4 && dst_fmt == 2'd2)
    |=> (result[30:23] != 8'hff));

endmodule

// File: tb/mx_widen_tb_top.sv
`timescale 1ns/1ps
module mx_widen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [2:0]  src_fmt = 3'd0;
  logic [1:0]  dst_fmt = 2'd0;
  logic [7:0]  code_in = 8'd0;
  logic        valid_out, fmt_err;
  logic [63:0] result;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mx_widen dut_i (.clk(clk), .rst_n(rst_n), .valid_in(valid_in), .src_fmt(src_fmt),
    .dst_fmt(dst_fmt), .code_in(code_in), .valid_out(valid_out), .result(result),
    .fmt_err(fmt_err));

  function automatic real p2(int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(int s, int d, int c, output string tag);
    int eb, mb, sb, kind, dm, de, db, dw, e, m, k, sg;
    real v, a;
    logic [63:0] sw, eall;
    longint mant;
    case (s)
      0: begin eb = 5; mb = 2; sb = 15; kind = 0; end
      1: begin eb = 4; mb = 3; sb = 7;  kind = 1; end
      2: begin eb = 3; mb = 2; sb = 3;  kind = 2; end
      3: begin eb = 2; mb = 3; sb = 1;  kind = 2; end
      default: begin eb = 2; mb = 1; sb = 1; kind = 2; end
    endcase
    case (d)
      0: begin dw = 16; dm = 10; de = 5;  db = 15;   end
      1: begin dw = 16; dm = 7;  de = 8;  db = 127;  end
      2: begin dw = 32; dm = 23; de = 8;  db = 127;  end
      default: begin dw = 64; dm = 52; de = 11; db = 1023; end
    endcase
    sg = (c >> (eb + mb)) & 1;
    e  = (c >> mb) & ((1 << eb) - 1);
    m  = c & ((1 << mb) - 1);
    sw = 64'(sg) << (dw - 1);
    eall = 64'((1 << de) - 1) << dm;
    if (kind == 0 && e == (1 << eb) - 1) begin
      if (m != 0) begin tag = "R5_nan_R8"; return eall | (64'd1 << (dm - 1)); end
      tag = "R5_inf"; return sw | eall;
    end
    if (kind == 1 && e == (1 << eb) - 1 && m == (1 << mb) - 1) begin
      tag = "R6_nan_R8"; return eall | (64'd1 << (dm - 1));
    end
    if (e == 0 && m == 0) begin tag = "R9_zero"; return sw; end
    if (e == 0) begin
      tag = "R4_sub";
      a = real'(m) * p2(1 - sb - mb);
    end else begin
      tag = (kind == 2) ? "R7_R3_norm" : ((kind == 1 && e == (1 << eb) - 1) ? "R6_norm" : "R3_norm");
      a = real'((1 << mb) + m) * p2(e - sb - mb);
    end
    v = a;
    k = 0;
    while (v >= p2(k + 1)) k++;
    while (v < p2(k)) k--;
    if (k + db <= 0) begin
      mant = longint'(a * p2(db - 1 + dm));
      return sw | 64'(mant);
    end
    mant = longint'((a / p2(k) - 1.0) * p2(dm));
    return sw | (64'(k + db) << dm) | 64'(mant);
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [63:0] exp;
    logic [63:0] last;
    repeat (3) @(negedge clk);
    chk("R12_valid", 64'(valid_out), 64'd0);
    chk("R12_result", result, 64'd0);
    chk("R12_err", 64'(fmt_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 5; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int c = 0; c < (1 << ((s < 2) ? 8 : (s < 4) ? 6 : 4)); c++) begin
          int w = (s < 2) ? 8 : (s < 4) ? 6 : 4;
          logic [7:0] junk = ((c + d) % 2 == 1) ? ~((8'd1 << w) - 8'd1) : 8'd0;
          exp = model(s, d, c, tag);
          valid_in = 1'b1; src_fmt = 3'(s); dst_fmt = 2'(d);
          code_in = 8'(c) | ((w < 8) ? junk : 8'd0);
          @(negedge clk);
          valid_in = 1'b0;
          chk({tag, (w < 8) ? "_R1" : "", (d < 3) ? "_R2" : ""}, result, exp);
          chk("R10_err_low", 64'(fmt_err), 64'd0);
          chk("R11_valid", 64'(valid_out), 64'd1);
        end
      end
    end

    last = result;
    @(negedge clk);
    chk("R11_idle_valid", 64'(valid_out), 64'd0);
    chk("R11_idle_hold", result, last);

    for (int s = 5; s < 8; s++) begin
      valid_in = 1'b1; src_fmt = 3'(s); dst_fmt = 2'(s - 4); code_in = 8'h3c;
      @(negedge clk);
      valid_in = 1'b0;
      chk("R10_zero", result, 64'd0);
      chk("R10_err", 64'(fmt_err), 64'd1);
    end

    valid_in = 1'b1; src_fmt = 3'd0; dst_fmt = 2'd2; code_in = 8'h3c;
    @(negedge clk);
    valid_in = 1'b0;
    chk("R3_one", result, 64'h3f80_0000);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12_valid2", 64'(valid_out), 64'd0);
    chk("R12_result2", result, 64'd0);
    rst_n = 1'b1;

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule